// File: doc/BRIEF.md
# Accumulator Rotate and Digit-Rotate Unit

This unit serves the datapath of an 8-bit processor core. On a strobe it takes the accumulator, the carry flag, a memory operand byte and an operation code. It then computes one of six rotations and registers the result. Four of the rotations work on the accumulator alone and move it by a single bit position. Two of them rotate with a copy of the outgoing bit into carry, and two rotate through the carry flag. The other two are digit rotations. They treat the accumulator's low nibble and the two nibbles of the memory byte as a 12-bit ring and move it by one nibble.

The core supplies the memory byte that its address logic has already fetched. The unit returns the new byte and a one-cycle write enable, and the core then stores the byte at the same address. Outputs hold their last values while no strobe arrives and while the strobe carries a reserved code.

Top module: `acc_rot_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R2: Code 0 (right rotate) sets acc bit 7 and carry from old acc bit 0, and moves every other bit down one place.
- R3: Code 1 (left rotate) sets acc bit 0 and carry from old acc bit 7, and moves every other bit up one place.
- R4: Code 2 (right rotate through carry) sets carry from old acc bit 0 and sets acc bit 7 from the old carry. The other bits move down one place.
- R5: Code 3 (left rotate through carry) sets carry from old acc bit 7 and sets acc bit 0 from the old carry. The other bits move up one place.
- R6: Code 4 (digit right) gives new acc[3:0] = mem[3:0], new mem[7:4] = acc[3:0] and new mem[3:0] = mem[7:4].
- R7: Code 5 (digit left) gives new acc[3:0] = mem[7:4], new mem[3:0] = acc[3:0] and new mem[7:4] = mem[3:0].
- R8: A digit rotation copies acc[7:4] and carry through from the inputs, and raises `mem_we` for exactly one cycle.
- R9: Codes 0 to 3 never raise `mem_we` and leave `mem_out` unchanged.
- R10: Results appear on the outputs on the clock edge that samples the strobe. With `op_valid` low, or with code 6 or 7, all outputs hold their values and `mem_we` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code (0..5 used, 6..7 reserved) |
| acc_in | input | 8 | Current accumulator |
| cy_in | input | 1 | Current carry flag |
| mem_in | input | 8 | Memory operand byte |
| acc_out | output | 8 | New accumulator |
| cy_out | output | 1 | New carry flag |
| mem_out | output | 8 | New memory byte |
| mem_we | output | 1 | Memory write enable, one-cycle pulse |

## Verification
The byte rotates are driven with values that carry a one in the bit that leaves the accumulator, with values that carry a zero there, and with both carry input levels. This shows whether the wrapped bit comes from the accumulator or from the carry, and whether the outgoing bit reaches the carry flag. The digit rotates are driven with byte values whose four nibbles all differ, so any swapped or misrouted nibble shows in the result. They are also driven with all-ones and all-zeros nibble pairs, which expose a stuck lane. Reserved codes, idle cycles and a reset in mid-run check that results hold and that the write enable stays a single pulse.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [2:0] {
    OP_ROR  = 3'd0,
    OP_ROL  = 3'd1,
    OP_RORC = 3'd2,
    OP_ROLC = 3'd3,
    OP_DIGR = 3'd4,
    OP_DIGL = 3'd5
  } rot_op_e;

  function automatic logic op_is_byte(input logic [2:0] op);
    return (op == OP_ROR) || (op == OP_ROL) || (op == OP_RORC) || (op == OP_ROLC);
  endfunction

  function automatic logic op_is_digit(input logic [2:0] op);
    return (op == OP_DIGR) || (op == OP_DIGL);
  endfunction
endpackage

// File: rtl/byte_rotator.sv
module byte_rotator #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic              cy_i,
  input  logic              left_i,
  input  logic              thru_cy_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              cy_o
);
  logic out_bit;
  logic in_bit;

  always_comb begin
    out_bit = left_i ? acc_i[DATA_W-1] : acc_i[0];
    in_bit  = thru_cy_i ? cy_i : out_bit;
    if (left_i) acc_o = {acc_i[DATA_W-2:0], in_bit};
    else        acc_o = {in_bit, acc_i[DATA_W-1:1]};
    cy_o = out_bit;
  end
endmodule

// File: rtl/digit_rotator.sv
module digit_rotator #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic              left_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] mem_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [NIB_W-1:0] a_lo, a_hi, m_lo, m_hi;

  always_comb begin
    a_lo = acc_i[NIB_W-1:0];
    a_hi = acc_i[DATA_W-1:NIB_W];
    m_lo = mem_i[NIB_W-1:0];
    m_hi = mem_i[DATA_W-1:NIB_W];
    if (left_i) begin
      acc_o = {a_hi, m_hi};
      mem_o = {m_lo, a_lo};
    end else begin
      acc_o = {a_hi, m_lo};
      mem_o = {a_lo, m_hi};
    end
  end
endmodule

// File: rtl/rot_result_reg.sv
module rot_result_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_acc,
  input  logic              ld_mem,
  input  logic [DATA_W-1:0] acc_d,
  input  logic              cy_d,
  input  logic [DATA_W-1:0] mem_d,
  output logic [DATA_W-1:0] acc_q,
  output logic              cy_q,
  output logic [DATA_W-1:0] mem_q,
  output logic              we_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
      mem_q <= '0;
      we_q  <= 1'b0;
    end else begin
      we_q <= ld_mem;
      if (ld_acc) begin
        acc_q <= acc_d;
        cy_q  <= cy_d;
      end
      if (ld_mem) mem_q <= mem_d;
    end
  end
endmodule

// File: rtl/acc_rot_unit.sv
module acc_rot_unit
  import rot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              cy_in,
  input  logic [DATA_W-1:0] mem_in,
  output logic [DATA_W-1:0] acc_out,
  output logic              cy_out,
  output logic [DATA_W-1:0] mem_out,
  output logic              mem_we
);
  logic              is_byte, is_digit;
  logic [DATA_W-1:0] br_acc, dr_acc, dr_mem, nxt_acc;
  logic              br_cy, nxt_cy;

  assign is_byte  = op_valid && op_is_byte(op_sel);
  assign is_digit = op_valid && op_is_digit(op_sel);

  byte_rotator #(.DATA_W(DATA_W)) u_brot (
    .acc_i     (acc_in),
    .cy_i      (cy_in),
    .left_i    (op_sel[0]),
    .thru_cy_i (op_sel[1]),
    .acc_o     (br_acc),
    .cy_o      (br_cy)
  );

  digit_rotator #(.DATA_W(DATA_W)) u_drot (
    .acc_i  (acc_in),
    .mem_i  (mem_in),
    .left_i (op_sel[0]),
    .acc_o  (dr_acc),
    .mem_o  (dr_mem)
  );

  always_comb begin
    nxt_acc = is_digit ? dr_acc : br_acc;
    nxt_cy  = is_digit ? cy_in  : br_cy;
  end

  rot_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk    (clk),
    .rst    (rst),
    .ld_acc (is_byte || is_digit),
    .ld_mem (is_digit),
    .acc_d  (nxt_acc),
    .cy_d   (nxt_cy),
    .mem_d  (dr_mem),
    .acc_q  (acc_out),
    .cy_q   (cy_out),
    .mem_q  (mem_out),
    .we_q   (mem_we)
  );
endmodule

// File: rtl/acc_rot_chk.sv
module acc_rot_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] acc_in,
  input logic              cy_in,
  input logic [DATA_W-1:0] mem_in,
  input logic [DATA_W-1:0] acc_out,
  input logic              cy_out,
  input logic [DATA_W-1:0] mem_out,
  input logic              mem_we
);
  localparam int NIB_W = DATA_W / 2;

  // R2
  a_r2_ror: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd0) |=>
      (acc_out == {$past(acc_in[0]), $past(acc_in[DATA_W-1:1])}) && (cy_out == $past(acc_in[0])));

  // R5
  a_r5_rolc: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd3) |=>
      (acc_out == {$past(acc_in[DATA_W-2:0]), $past(cy_in)}) && (cy_out == $past(acc_in[DATA_W-1])));

  // R6
  a_r6_digr_mem: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd4) |=>
      mem_out == {$past(acc_in[NIB_W-1:0]), $past(mem_in[DATA_W-1:NIB_W])});

  // R8
  a_r8_digit_keep: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == 3'd4 || op_sel == 3'd5)) |=>
      mem_we && (cy_out == $past(cy_in)) &&
      (acc_out[DATA_W-1:NIB_W] == $past(acc_in[DATA_W-1:NIB_W])));

  // R8
  a_r8_we_pulse: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !(op_valid && (op_sel == 3'd4 || op_sel == 3'd5))) |=> !mem_we);

  // R9
  a_r9_byte_no_we: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel < 3'd4) |=> (!mem_we && $stable(mem_out)));

  // R10
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_sel > 3'd5) |=>
      (!mem_we && $stable(acc_out) && $stable(cy_out) && $stable(mem_out)));
endmodule

bind acc_rot_unit acc_rot_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
  .acc_in(acc_in), .cy_in(cy_in), .mem_in(mem_in),
  .acc_out(acc_out), .cy_out(cy_out), .mem_out(mem_out), .mem_we(mem_we)
);

// File: tb/sim_acc_rot_unit.sv
module sim_acc_rot_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  // {op[3], acc[8], cy, mem[8], exp_acc[8], exp_cy, exp_mem[8], exp_we}
  localparam logic [37:0] VEC [NVEC] = '{
    {3'd0, 8'h81, 1'b0, 8'h00, 8'hC0, 1'b1, 8'h00, 1'b0}, // R2
    {3'd0, 8'h02, 1'b1, 8'h00, 8'h01, 1'b0, 8'h00, 1'b0}, // R2
    {3'd1, 8'h81, 1'b0, 8'h00, 8'h03, 1'b1, 8'h00, 1'b0}, // R3
    {3'd1, 8'h40, 1'b1, 8'h00, 8'h80, 1'b0, 8'h00, 1'b0}, // R3
    {3'd2, 8'h01, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0}, // R4
    {3'd2, 8'h00, 1'b1, 8'h00, 8'h80, 1'b0, 8'h00, 1'b0}, // R4
    {3'd2, 8'hA5, 1'b1, 8'h00, 8'hD2, 1'b1, 8'h00, 1'b0}, // R4
    {3'd3, 8'h80, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0}, // R5
    {3'd3, 8'h00, 1'b1, 8'h00, 8'h01, 1'b0, 8'h00, 1'b0}, // R5
    {3'd3, 8'h5A, 1'b0, 8'h00, 8'hB4, 1'b0, 8'h00, 1'b0}, // R5
    {3'd4, 8'h3C, 1'b1, 8'h7E, 8'h3E, 1'b1, 8'hC7, 1'b1}, // R6
    {3'd5, 8'h3C, 1'b0, 8'h7E, 8'h37, 1'b0, 8'hEC, 1'b1}, // R7
    {3'd4, 8'hF0, 1'b0, 8'h0F, 8'hFF, 1'b0, 8'h00, 1'b1}, // R6
    {3'd5, 8'h12, 1'b1, 8'h34, 8'h13, 1'b1, 8'h42, 1'b1}  // R7
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] acc_in = 8'h00;
  logic       cy_in = 1'b0;
  logic [7:0] mem_in = 8'h00;
  logic [7:0] acc_out, mem_out;
  logic       cy_out, mem_we;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  acc_rot_unit #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .cy_in(cy_in), .mem_in(mem_in),
    .acc_out(acc_out), .cy_out(cy_out), .mem_out(mem_out), .mem_we(mem_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [7:0] a, input logic c, input logic [7:0] m);
    op_valid = v; op_sel = op; acc_in = a; cy_in = c; mem_in = m;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] prev_mem, h_acc, h_mem;
    logic       h_cy;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "acc_out", acc_out, 8'h00);
    chk("R1", "cy_out", {7'd0, cy_out}, 8'h00);
    chk("R1", "mem_out", mem_out, 8'h00);
    chk("R1", "mem_we", {7'd0, mem_we}, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [37:0] v;
      string rq;
      v = VEC[i];
      rq = (v[37:35] == 3'd0) ? "R2" : (v[37:35] == 3'd1) ? "R3" :
           (v[37:35] == 3'd2) ? "R4" : (v[37:35] == 3'd3) ? "R5" :
           (v[37:35] == 3'd4) ? "R6" : "R7";
      prev_mem = mem_out;
      drive(1'b1, v[37:35], v[34:27], v[26], v[25:18]);
      // R10: result visible one edge after the strobe
      chk(rq, "acc_out", acc_out, v[17:10]);
      chk(rq, "cy_out", {7'd0, cy_out}, {7'd0, v[9]});
      if (v[0]) begin
        chk(rq, "mem_out", mem_out, v[8:1]);
        chk("R8", "mem_we high", {7'd0, mem_we}, 8'h01);
      end else begin
        chk("R9", "mem_out held", mem_out, prev_mem);
        chk("R9", "mem_we low", {7'd0, mem_we}, 8'h00);
      end
      @(negedge clk);
      chk("R8", "mem_we single cycle", {7'd0, mem_we}, 8'h00);
      chk("R10", "acc held while idle", acc_out, v[17:10]);
    end

    // R10: reserved codes change nothing
    h_acc = acc_out; h_cy = cy_out; h_mem = mem_out;
    drive(1'b1, 3'd6, 8'h55, ~h_cy, 8'hAA);
    chk("R10", "op6 acc", acc_out, h_acc);
    chk("R10", "op6 cy", {7'd0, cy_out}, {7'd0, h_cy});
    chk("R10", "op6 mem", mem_out, h_mem);
    chk("R10", "op6 we", {7'd0, mem_we}, 8'h00);
    drive(1'b1, 3'd7, 8'h55, ~h_cy, 8'hAA);
    chk("R10", "op7 acc", acc_out, h_acc);
    chk("R10", "op7 we", {7'd0, mem_we}, 8'h00);
    // R10: inputs with strobe low are ignored
    drive(1'b0, 3'd4, 8'h99, 1'b1, 8'h66);
    chk("R10", "no strobe acc", acc_out, h_acc);
    chk("R10", "no strobe mem", mem_out, h_mem);
    chk("R10", "no strobe we", {7'd0, mem_we}, 8'h00);

    // R8: back-to-back digit ops keep we high for each
    drive(1'b1, 3'd4, 8'hA1, 1'b0, 8'hB2);
    chk("R6", "b2b acc", acc_out, 8'hA2);
    chk("R6", "b2b mem", mem_out, 8'h1B);
    drive(1'b1, 3'd5, 8'hA1, 1'b1, 8'hB2);
    chk("R7", "b2b acc", acc_out, 8'hAB);
    chk("R7", "b2b mem", mem_out, 8'h21);
    chk("R8", "b2b cy", {7'd0, cy_out}, 8'h01);
    chk("R8", "b2b we", {7'd0, mem_we}, 8'h01);

    // R1: mid-run reset
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "mid reset acc", acc_out, 8'h00);
    chk("R1", "mid reset mem", mem_out, 8'h00);
    chk("R1", "mid reset cy", {7'd0, cy_out}, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule